// File: doc/BRIEF.md
# Level-1 Latency Pipeline with Event Buffer

This block stores the 96-bit hit pattern of every beam crossing in a circular pipeline that is 64 crossings deep, so that each pattern remains available until the level-1 trigger decision arrives. The decision latency is set by a 6-bit input. When an accept is presented, the block takes the pattern written that many crossings earlier. It pairs the pattern with that crossing's 16-bit clock stamp and places the result in a derandomizing buffer that holds up to five whole events.

The crate controller drains the buffer one 16-bit word at a time. It raises a read strobe, and one cycle later the block answers with data-valid and a word, but only if an event is waiting. A busy output shows that all event slots are taken. An accept that arrives while the block is busy is discarded, and a sticky overflow flag records the loss. A synchronous, active-high reset clears all stored state.

Top module: `l1_event_buffer`

## Requirements
- R1: After a synchronous reset, busy and overflow read 0, the buffer holds no event, and a read strobe returns no data-valid.
- R2: An accept in the cycle in which crossing n is written captures the pattern of crossing n-L, where L is the latency input (1 to 63). The pipeline keeps working across its 64-entry wrap.
- R3: An event is returned as seven words. Words 0 to 5 are pattern bits [15:0], [31:16] and so on up to [95:80]. Word 6 is the clock stamp, which is the crossing number n-L counted from 0 after reset, modulo 2^16.
- R4: data_valid is high in the cycle after a read strobe only if an event was held. A strobe to an empty buffer gives no data-valid.
- R5: Events are returned in the order of their accepts, and up to five are held at once.
- R6: busy is high exactly while five events are held, and it drops once one event has been fully read.
- R7: An accept that arrives while busy is dropped and sets overflow. Overflow stays set until reset.
- R8: An accept in the same cycle as the last word of a readout is stored, and it is read out next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beam crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| pattern_in | input | 96 | Hit pattern of the current crossing |
| latency | input | 6 | Accept latency in crossings (1 to 63) |
| l1_accept | input | 1 | Level-1 accept for crossing now minus latency |
| rd_strobe | input | 1 | Request for the next readout word |
| data_valid | output | 1 | The word on data_out is valid |
| data_out | output | 16 | Readout word |
| busy | output | 1 | All event slots are full |
| overflow | output | 1 | Sticky flag: an accept was dropped |

## Verification
Each crossing carries a pattern derived from its crossing number, with different contents in every 16-bit lane. A word read from the wrong lane, the wrong crossing or the wrong latency offset therefore shows up as a value mismatch. A table of latencies and idle gaps, from 1 up to 63 and run after the pipeline has wrapped, separates correct tap arithmetic from off-by-one and wrap faults. Directed sequences cover the rest: filling all five slots back to back, an extra accept while full, draining in order, strobes to an empty buffer, and an accept coinciding with the final word. Together these separate order, busy, drop and simultaneous push/pop handling.

// File: rtl/l1_event_buffer.sv
module l1_event_buffer #(
  parameter int PAT_W      = 96,
  parameter int WORD_W     = 16,
  parameter int PIPE_DEPTH = 64,
  parameter int SLOTS      = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [PAT_W-1:0]              pattern_in,
  input  logic [$clog2(PIPE_DEPTH)-1:0] latency,
  input  logic                          l1_accept,
  input  logic                          rd_strobe,
  output logic                          data_valid,
  output logic [WORD_W-1:0]             data_out,
  output logic                          busy,
  output logic                          overflow
);
  localparam int WORDS  = PAT_W / WORD_W;
  localparam int PTR_W  = $clog2(PIPE_DEPTH);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CNT_W  = $clog2(SLOTS + 1);
  localparam int WIDX_W = $clog2(WORDS + 1);

  logic [PAT_W-1:0]  pipe     [PIPE_DEPTH];
  logic [PAT_W-1:0]  ev_pat   [SLOTS];
  logic [WORD_W-1:0] ev_stamp [SLOTS];
  logic [PTR_W-1:0]  wr_ptr;
  logic [WORD_W-1:0] bcnt;
  logic [SLOT_W-1:0] head, tail;
  logic [CNT_W-1:0]  fill;
  logic [WIDX_W-1:0] widx;

  function automatic logic [SLOT_W-1:0] nxt(input logic [SLOT_W-1:0] p);
    return (p == SLOT_W'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  wire              have      = fill != '0;
  wire              last_word = widx == WIDX_W'(WORDS);
  wire              push      = l1_accept && !busy;
  wire              pop       = rd_strobe && have && last_word;
  wire [PTR_W-1:0]  tap       = wr_ptr - latency;
  wire [PAT_W-1:0]  shifted   = ev_pat[head] >> (widx * WORD_W);
  wire [WORD_W-1:0] cur_word  = last_word ? ev_stamp[head] : shifted[WORD_W-1:0];

  assign busy = fill == CNT_W'(SLOTS);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PIPE_DEPTH; i++) pipe[i] <= '0;
      wr_ptr <= '0;
      bcnt   <= '0;
    end else begin
      pipe[wr_ptr] <= pattern_in;
      wr_ptr       <= wr_ptr + 1'b1;
      bcnt         <= bcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) begin
        ev_pat[i]   <= '0;
        ev_stamp[i] <= '0;
      end
      head       <= '0;
      tail       <= '0;
      fill       <= '0;
      widx       <= '0;
      overflow   <= 1'b0;
      data_valid <= 1'b0;
      data_out   <= '0;
    end else begin
      if (push) begin
        ev_pat[tail]   <= pipe[tap];
        ev_stamp[tail] <= bcnt - WORD_W'(latency);
        tail           <= nxt(tail);
      end
      if (l1_accept && busy) overflow <= 1'b1;
      data_valid <= rd_strobe && have;
      if (rd_strobe && have) begin
        data_out <= cur_word;
        widx     <= last_word ? '0 : widx + 1'b1;
      end
      if (pop) head <= nxt(head);
      fill <= fill + CNT_W'(push) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/l1_event_buffer_chk.sv
module l1_event_buffer_chk #(
  parameter int SLOTS = 5,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             l1_accept,
  input logic             rd_strobe,
  input logic             data_valid,
  input logic             busy,
  input logic             overflow,
  input logic [CNT_W-1:0] fill
);
  AST_DV_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst) data_valid |-> $past(rd_strobe)); // R4
  AST_NO_DV_EMPTY: assert property (@(posedge clk) disable iff (rst) (fill == '0) |=> !data_valid); // R4
  AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (rst) fill <= CNT_W'(SLOTS)); // R5
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(l1_accept)); // R6
  AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (rst) (busy && l1_accept) |=> overflow); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) overflow |=> overflow); // R7
endmodule

bind l1_event_buffer l1_event_buffer_chk #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .l1_accept(l1_accept), .rd_strobe(rd_strobe),
  .data_valid(data_valid), .busy(busy), .overflow(overflow), .fill(fill)
);

// File: tb/l1_event_buffer_test.sv
module l1_event_buffer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [95:0] pattern_in;
  logic [5:0]  latency = 6'd1;
  logic        l1_accept = 1'b0;
  logic        rd_strobe = 1'b0;
  logic        data_valid;
  logic [15:0] data_out;
  logic        busy;
  logic        overflow;
  int          xing;
  int          checks = 0;
  int          fails = 0;

  always #2.5 clk = ~clk;

  l1_event_buffer uut (
    .clk(clk), .rst(rst), .pattern_in(pattern_in), .latency(latency),
    .l1_accept(l1_accept), .rd_strobe(rd_strobe), .data_valid(data_valid),
    .data_out(data_out), .busy(busy), .overflow(overflow)
  );

  function automatic logic [95:0] pat(input int n);
    logic [95:0] p;
    for (int i = 0; i < 6; i++) p[i*16 +: 16] = 16'((n * 37 + i * 16'h2111) ^ 16'h5A3C);
    return p;
  endfunction

  always_ff @(posedge clk) xing <= rst ? 0 : xing + 1;
  assign pattern_in = pat(xing);

  // Stimulus vectors: {latency, idle crossings before the accept}
  localparam int TBL [6][2] = '{'{1, 3}, '{5, 0}, '{17, 10}, '{32, 2}, '{63, 5}, '{40, 1}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic accept(output int c);
    l1_accept = 1'b1;
    c = xing - int'(latency);
    @(negedge clk);
    l1_accept = 1'b0;
  endtask

  task automatic read_word(input int c, input int w, input string req);
    logic [15:0] exp;
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    exp = (w == 6) ? 16'(c) : pat(c)[w*16 +: 16];
    chk(data_valid === 1'b1, {req, " data_valid"}, int'(data_valid), 1);
    chk(data_out === exp, {req, " word"}, int'(data_out), int'(exp));
  endtask

  task automatic read_event(input int c, input string req);
    for (int w = 0; w < 7; w++) read_word(c, w, req);
  endtask

  task automatic empty_strobe(input string req);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    chk(data_valid === 1'b0, req, int'(data_valid), 0);
  endtask

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int c, c2;
    idle(3);
    rst = 1'b0;
    chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(overflow === 1'b0, "R1 overflow after reset", int'(overflow), 0);
    empty_strobe("R1 no data after reset");

    idle(70);
    for (int k = 0; k < 6; k++) begin
      latency = 6'(TBL[k][0]);
      idle(TBL[k][1]);
      accept(c);
      read_event(c, "R2 R3 table");
    end

    empty_strobe("R4 strobe on empty buffer");

    latency = 6'd8;
    begin
      int cs [6];
      for (int k = 0; k < 5; k++) accept(cs[k]);
      chk(busy === 1'b1, "R6 busy with five events", int'(busy), 1);
      chk(overflow === 1'b0, "R7 no overflow yet", int'(overflow), 0);
      accept(cs[5]);
      chk(overflow === 1'b1, "R7 overflow on dropped accept", int'(overflow), 1);
      chk(busy === 1'b1, "R6 busy after drop", int'(busy), 1);
      read_event(cs[0], "R5 first event");
      chk(busy === 1'b0, "R6 busy drops after one readout", int'(busy), 0);
      for (int k = 1; k < 5; k++) read_event(cs[k], "R5 order");
    end
    empty_strobe("R7 dropped accept not stored");
    chk(overflow === 1'b1, "R7 overflow sticky", int'(overflow), 1);

    latency = 6'd12;
    accept(c);
    for (int w = 0; w < 6; w++) read_word(c, w, "R8 event before push");
    l1_accept = 1'b1;
    c2 = xing - 12;
    read_word(c, 6, "R8 stamp with push");
    l1_accept = 1'b0;
    read_event(c2, "R8 event pushed at pop");
    empty_strobe("R8 buffer empty afterwards");

    accept(c);
    rst = 1'b1;
    idle(1);
    rst = 1'b0;
    chk(overflow === 1'b0, "R1 overflow cleared by reset", int'(overflow), 0);
    chk(busy === 1'b0, "R1 busy cleared by reset", int'(busy), 0);
    empty_strobe("R1 event cleared by reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule